// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock Core

This block keeps wall-clock time as a 32-bit count of elapsed seconds. The count advances on a one-cycle strobe from a one-pulse-per-second source. Software reaches the block through a small 16-bit register port. The time count and the alarm value are each split into an upper-word register and a lower-word register. An alarm comparator raises a single-cycle interrupt when the running count reaches the programmed alarm value while the alarm is enabled. A second interrupt output pulses periodically, at a power-of-two rate derived from a 32768 Hz tick strobe.

Setting the time is a two-step operation. The upper word goes into a shadow register. Writing the lower word is the commit request. A commit state machine holds the staged value, shows a busy flag, and loads the value into the running count on the next seconds boundary. The states are `ST_IDLE`, `ST_ARMED` and `ST_LOAD`:
- `ST_IDLE` goes to `ST_ARMED` on an unlocked lower-word write.
- `ST_ARMED` goes to `ST_LOAD` on a seconds strobe.
- `ST_LOAD` goes back to `ST_IDLE`, or to `ST_ARMED` if a new unlocked lower-word write arrives in that cycle.

A lower-word write made while the write-lock input is high is dropped. Each completed commit sets the sticky valid flag. It also latches the current value of a free-running pseudo-random generator into a read-only write-counter register.

Register map, word addresses on `bus_addr_i`:

| Address | Register | Access |
|---|---|---|
| 0 | write counter | read-only |
| 1 | time upper word | write goes to the shadow |
| 2 | time lower word | write is the commit request |
| 3 | alarm upper word | read/write |
| 4 | alarm lower word | read/write |
| 5 | control | see R8 |
| 6 | trim | read/write |
| 7 | unused | reads 0 |

Top module: `sec_rtc_core`

## Requirements
- R1: After reset, every address 0 to 7 reads 0 and both interrupt outputs are low.
- R2: Reads of address 1 return count[31:16] and reads of address 2 return count[15:0]. The alarm words written at addresses 3 (upper) and 4 (lower) read back unchanged.
- R3: Each cycle with `pps_i` high, while no commit is pending, increments the count by exactly one. The increment carries from the lower word into the upper word, and the count wraps from FFFFFFFF to 0.
- R4: A write to address 1 changes only the shadow, so the count is unaffected. An unlocked write to address 2 sets control bit 14 (busy) from the next cycle, and the count holds until the next seconds strobe.
- R5: The count equals the staged value {shadow, lower word} from the second clock edge after the seconds strobe that follows the commit request. Busy clears on that same edge, and control bit 15 (valid) becomes 1 and stays 1.
- R6: While `wr_lock_i` is high, a write to address 2 leaves busy, valid, the count and the write counter unchanged. The next seconds strobe then increments the old count.
- R7: Every completed commit loads the write counter with a nonzero value that differs from its previous value. Writes to address 0 have no effect.
- R8: In the control register only bit 10 (alarm enable) and bits 6:4 (periodic rate field) are writable. All other bits read 0 apart from bits 15 and 14.
- R9: With the alarm enabled, `alarm_irq_o` pulses for exactly one cycle, one cycle after the count and the alarm become equal or after the enable is set while they are equal. It does not repeat while they stay equal, and it never fires while the alarm is disabled.
- R10: With rate field n from 1 to 7, `periodic_irq_o` gives one-cycle pulses every 2^(15-n) cycles of `sub_tick_i`, which is a 2^n Hz rate from a 32768 Hz tick. With n = 0 it stays low.
- R11: The trim register at address 6 stores bits 9:0 of the write data and reads bits 15:10 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pps_i | input | 1 | one-cycle strobe once per second |
| sub_tick_i | input | 1 | one-cycle strobe at 32768 Hz |
| wr_lock_i | input | 1 | when high, time commit requests are dropped |
| bus_sel_i | input | 1 | register access select |
| bus_wr_i | input | 1 | write qualifier for the access |
| bus_addr_i | input | 3 | register word address |
| bus_wdata_i | input | 16 | write data |
| bus_rdata_o | output | 16 | read data, combinational on the address |
| alarm_irq_o | output | 1 | single-cycle alarm event |
| periodic_irq_o | output | 1 | single-cycle periodic event |

## Verification
The checker watches several properties on every cycle:
- the count moves only after a seconds strobe or a commit load;
- valid never falls, and it rises only out of a busy state;
- a locked lower-word write leaves busy, valid and the write counter alone;
- the write counter changes only on a load, and the generator never reaches zero;
- each interrupt pulse lasts one cycle, and an alarm pulse is always preceded by an enabled match.

Only the bench scenarios can show the arithmetic results:
- the committed value, the increment sweep and the wrap and carry points;
- the register masks;
- the exact spacing of periodic pulses for every rate setting;
- that an alarm fires exactly once per match episode.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int unsigned ADDR_W = 3;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_WCNT    = 3'd0;
    localparam logic [ADDR_W-1:0] A_TIME_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIME_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_ALM_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ALM_LO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd5;
    localparam logic [ADDR_W-1:0] A_TRIM    = 3'd6;

    // control register bit positions
    localparam int unsigned CTL_VALID_BIT = 15;
    localparam int unsigned CTL_BUSY_BIT  = 14;
    localparam int unsigned CTL_ALMEN_BIT = 10;
    localparam int unsigned CTL_FREQ_LSB  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOAD  = 2'd2
    } commit_state_e;

endpackage

// File: rtl/sec_rtc_commit.sv
module sec_rtc_commit
    import sec_rtc_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stage_req,
    input  logic                  lock,
    input  logic                  pps,
    input  logic [HALF_W-1:0]     hi_word,
    input  logic [HALF_W-1:0]     lo_word,
    output logic [2*HALF_W-1:0]   staged_o,
    output logic                  busy_o,
    output logic                  load_o,
    output logic                  valid_o
);

    commit_state_e state_q, state_d;
    logic          stage_ok;
    logic [2*HALF_W-1:0] staged_q;
    logic          valid_q;

    assign stage_ok = stage_req && !lock;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (stage_ok) state_d = ST_ARMED;
            ST_ARMED: if (pps)      state_d = ST_LOAD;
            ST_LOAD:  state_d = stage_ok ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy_o = 1'b0;
        load_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin busy_o = 1'b0; load_o = 1'b0; end
            ST_ARMED: begin busy_o = 1'b1; load_o = 1'b0; end
            ST_LOAD:  begin busy_o = 1'b1; load_o = 1'b1; end
            default:  begin busy_o = 1'b0; load_o = 1'b0; end
        endcase
    end

    // staging register and sticky valid flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (stage_ok)                 staged_q <= {hi_word, lo_word};
            if (state_q == ST_LOAD)       valid_q  <= 1'b1;
        end
    end

    assign staged_o = staged_q;
    assign valid_o  = valid_q;

endmodule

// File: rtl/sec_rtc_lfsr.sv
module sec_rtc_lfsr #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);

    logic [W-1:0] s_q, s_d;

    // Galois form: shift right, fold taps in when the outgoing bit is set
    always_comb begin
        s_d = s_q >> 1;
        if (s_q[0]) s_d = s_d ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEED;
        else        s_q <= s_d;
    end

    assign state_o = s_q;

endmodule

// File: rtl/sec_rtc_periodic.sv
module sec_rtc_periodic #(
    parameter int unsigned TICK_LOG2 = 15,
    parameter int unsigned FREQ_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [FREQ_W-1:0] freq,
    output logic              pulse_o
);

    localparam int unsigned PRE_W = TICK_LOG2;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             fire;
    logic             pulse_q;

    // divide ratio 2^(TICK_LOG2 - freq): low bits of the prescaler wrap
    always_comb begin
        mask = {PRE_W{1'b1}} >> freq;
        fire = tick && (freq != '0) && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (tick) pre_q <= pre_q + 1'b1;
            pulse_q <= fire;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] alarm,
    input  logic             enable,
    output logic             irq_o
);

    logic match, match_q, irq_q;

    assign match = enable && (count == alarm);

    // rising edge of the enabled match gives a one-cycle event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            match_q <= match;
            irq_q   <= match && !match_q;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
    import sec_rtc_pkg::*;
#(
    parameter int unsigned REG_W     = 16,
    parameter int unsigned TRIM_W    = 10,
    parameter int unsigned FREQ_W    = 3,
    parameter int unsigned TICK_LOG2 = 15,
    parameter logic [REG_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [REG_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_i,
    input  logic              sub_tick_i,
    input  logic              wr_lock_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              alarm_irq_o,
    output logic              periodic_irq_o
);

    localparam int unsigned CNT_W = 2 * REG_W;

    logic              wr_en;
    logic              lo_wr;
    logic [REG_W-1:0]  shadow_hi_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  alarm_q;
    logic              alm_en_q;
    logic [FREQ_W-1:0] freq_q;
    logic [TRIM_W-1:0] trim_q;
    logic [REG_W-1:0]  wcnt_q;
    logic [REG_W-1:0]  lfsr_s;
    logic [CNT_W-1:0]  staged;
    logic              busy;
    logic              load_now;
    logic              valid;
    logic [REG_W-1:0]  ctrl_rd;

    assign wr_en = bus_sel_i && bus_wr_i;
    assign lo_wr = wr_en && (bus_addr_i == A_TIME_LO);

    sec_rtc_commit #(.HALF_W(REG_W)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_req(lo_wr),
        .lock     (wr_lock_i),
        .pps      (pps_i),
        .hi_word  (shadow_hi_q),
        .lo_word  (bus_wdata_i),
        .staged_o (staged),
        .busy_o   (busy),
        .load_o   (load_now),
        .valid_o  (valid)
    );

    sec_rtc_lfsr #(.W(REG_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_o(lfsr_s)
    );

    sec_rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count_q),
        .alarm (alarm_q),
        .enable(alm_en_q),
        .irq_o (alarm_irq_o)
    );

    sec_rtc_periodic #(.TICK_LOG2(TICK_LOG2), .FREQ_W(FREQ_W)) u_periodic (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sub_tick_i),
        .freq   (freq_q),
        .pulse_o(periodic_irq_o)
    );

    // seconds counter: a load wins over a strobe; a pending commit consumes the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count_q <= '0;
        else if (load_now)         count_q <= staged;
        else if (pps_i && !busy)   count_q <= count_q + 1'b1;
    end

    // write counter snapshot of the free-running generator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wcnt_q <= '0;
        else if (load_now) wcnt_q <= lfsr_s;
    end

    // software-writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_hi_q <= '0;
            alarm_q     <= '0;
            alm_en_q    <= 1'b0;
            freq_q      <= '0;
            trim_q      <= '0;
        end else if (wr_en) begin
            case (bus_addr_i)
                A_TIME_HI: shadow_hi_q <= bus_wdata_i;
                A_ALM_HI:  alarm_q[CNT_W-1:REG_W] <= bus_wdata_i;
                A_ALM_LO:  alarm_q[REG_W-1:0]     <= bus_wdata_i;
                A_CTRL: begin
                    alm_en_q <= bus_wdata_i[CTL_ALMEN_BIT];
                    freq_q   <= bus_wdata_i[CTL_FREQ_LSB +: FREQ_W];
                end
                A_TRIM:    trim_q <= bus_wdata_i[TRIM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_rd                              = '0;
        ctrl_rd[CTL_VALID_BIT]               = valid;
        ctrl_rd[CTL_BUSY_BIT]                = busy;
        ctrl_rd[CTL_ALMEN_BIT]               = alm_en_q;
        ctrl_rd[CTL_FREQ_LSB +: FREQ_W]      = freq_q;
    end

    // read multiplexer
    always_comb begin
        case (bus_addr_i)
            A_WCNT:    bus_rdata_o = wcnt_q;
            A_TIME_HI: bus_rdata_o = count_q[CNT_W-1:REG_W];
            A_TIME_LO: bus_rdata_o = count_q[REG_W-1:0];
            A_ALM_HI:  bus_rdata_o = alarm_q[CNT_W-1:REG_W];
            A_ALM_LO:  bus_rdata_o = alarm_q[REG_W-1:0];
            A_CTRL:    bus_rdata_o = ctrl_rd;
            A_TRIM:    bus_rdata_o = {{(REG_W-TRIM_W){1'b0}}, trim_q};
            default:   bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker
    import sec_rtc_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pps_i,
    input logic               wr_lock_i,
    input logic               bus_sel_i,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               alarm_irq_o,
    input logic               periodic_irq_o,
    input logic [2*REG_W-1:0] count,
    input logic [2*REG_W-1:0] alarm,
    input logic               alm_en,
    input logic               busy,
    input logic               load_now,
    input logic               valid,
    input logic [REG_W-1:0]   wcnt,
    input logic [REG_W-1:0]   lfsr
);

    logic lo_req;
    assign lo_req = bus_sel_i && bus_wr_i && (bus_addr_i == A_TIME_LO);

    p_count_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pps_i) && !$past(load_now)) |-> $stable(count));

    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    p_valid_from_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(busy));

    p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_req && wr_lock_i && !busy) |=> (!busy && $stable(valid) && $stable(wcnt)));

    p_wcnt_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt != $past(wcnt)) |-> $past(load_now));

    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

    p_alarm_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_o |=> !alarm_irq_o);

    p_alarm_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_o |-> $past(alm_en && (count == alarm)));

    p_periodic_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_irq_o |=> !periodic_irq_o);

endmodule

bind sec_rtc_core sec_rtc_checker #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pps_i         (pps_i),
    .wr_lock_i     (wr_lock_i),
    .bus_sel_i     (bus_sel_i),
    .bus_wr_i      (bus_wr_i),
    .bus_addr_i    (bus_addr_i),
    .alarm_irq_o   (alarm_irq_o),
    .periodic_irq_o(periodic_irq_o),
    .count         (count_q),
    .alarm         (alarm_q),
    .alm_en        (alm_en_q),
    .busy          (busy),
    .load_now      (load_now),
    .valid         (valid),
    .wcnt          (wcnt_q),
    .lfsr          (lfsr_s)
);

// File: tb/test_sec_rtc_core.sv
`timescale 1ns/1ps
module test_sec_rtc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_i = 1'b0;
    logic        sub_tick_i = 1'b0;
    logic        wr_lock_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        alarm_irq_o;
    logic        periodic_irq_o;

    int checks = 0;
    int errors = 0;
    int alm_pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sec_rtc_core i_sec_rtc_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .pps_i         (pps_i),
        .sub_tick_i    (sub_tick_i),
        .wr_lock_i     (wr_lock_i),
        .bus_sel_i     (bus_sel_i),
        .bus_wr_i      (bus_wr_i),
        .bus_addr_i    (bus_addr_i),
        .bus_wdata_i   (bus_wdata_i),
        .bus_rdata_o   (bus_rdata_o),
        .alarm_irq_o   (alarm_irq_o),
        .periodic_irq_o(periodic_irq_o)
    );

    always @(negedge clk) if (alarm_irq_o) alm_pulses = alm_pulses + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic rd_time(output logic [31:0] t);
        logic [15:0] h, l;
        rd(3'd1, h);
        rd(3'd2, l);
        t = {h, l};
    endtask

    task automatic pulse_pps;
        @(negedge clk); pps_i = 1'b1;
        @(negedge clk); pps_i = 1'b0;
    endtask

    task automatic set_time(input logic [31:0] v);
        wr(3'd1, v[31:16]);
        wr(3'd2, v[15:0]);
        pulse_pps;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv, wc_prev;
        logic [31:0] t, t0;
        int base;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every address and both interrupts
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            chk("R1 reset read", {16'h0, rv}, 32'h0);
        end
        chk("R1 alarm irq low", {31'h0, alarm_irq_o}, 32'h0);
        chk("R1 periodic irq low", {31'h0, periodic_irq_o}, 32'h0);

        // R8: control write mask
        wr(3'd5, 16'hFFFF); rd(3'd5, rv);
        chk("R8 ctrl mask", {16'h0, rv}, 32'h0470);
        wr(3'd5, 16'h0000); rd(3'd5, rv);
        chk("R8 ctrl clear", {16'h0, rv}, 32'h0);

        // R11: trim width
        wr(3'd6, 16'hFFFF); rd(3'd6, rv);
        chk("R11 trim all ones", {16'h0, rv}, 32'h03FF);
        wr(3'd6, 16'hA955); rd(3'd6, rv);
        chk("R11 trim pattern", {16'h0, rv}, 32'h0155);

        // R2: alarm words read back
        wr(3'd3, 16'hA5A5); wr(3'd4, 16'h5A5A);
        rd(3'd3, rv); chk("R2 alarm hi", {16'h0, rv}, 32'hA5A5);
        rd(3'd4, rv); chk("R2 alarm lo", {16'h0, rv}, 32'h5A5A);

        // R4: shadow then commit request
        wr(3'd1, 16'h1234);
        rd_time(t); chk("R4 hi write no effect", t, 32'h0);
        rd(3'd5, rv); chk("R4 not busy after hi", {16'h0, rv}, 32'h0);
        wr(3'd2, 16'h5678);
        rd(3'd5, rv); chk("R4 busy after lo", {16'h0, rv}, 32'h4000);
        rd_time(t); chk("R4 count holds while armed", t, 32'h0);

        // R5: commit on seconds boundary
        pulse_pps; @(negedge clk);
        rd_time(t); chk("R5 committed value", t, 32'h12345678);
        rd(3'd5, rv); chk("R5 valid set busy clear", {16'h0, rv}, 32'h8000);
        rd(3'd0, wc_prev);
        checks++;
        if (wc_prev == 16'h0) begin errors++; $display("FAIL R7 wcnt nonzero: actual %h expected nonzero", wc_prev); end

        // R3: increment sweep
        for (int k = 1; k <= 8; k++) begin
            pulse_pps;
            rd_time(t); chk("R3 increment", t, 32'h12345678 + 32'(k));
        end

        // R3 carry across words, R7 write counter changes per commit
        set_time(32'h0000FFFF);
        rd(3'd0, rv);
        checks++;
        if (rv == wc_prev || rv == 16'h0) begin errors++; $display("FAIL R7 wcnt change: actual %h expected not %h", rv, wc_prev); end
        wc_prev = rv;
        pulse_pps; rd_time(t); chk("R3 carry", t, 32'h00010000);

        set_time(32'hFFFFFFFF);
        rd(3'd0, rv);
        checks++;
        if (rv == wc_prev || rv == 16'h0) begin errors++; $display("FAIL R7 wcnt change: actual %h expected not %h", rv, wc_prev); end
        wc_prev = rv;
        rd_time(t); chk("R5 commit all ones", t, 32'hFFFFFFFF);
        pulse_pps; rd_time(t); chk("R3 wrap", t, 32'h0);

        // R7: write counter is read-only
        wr(3'd0, 16'h1111); rd(3'd0, rv);
        chk("R7 wcnt write ignored", {16'h0, rv}, {16'h0, wc_prev});

        // R6: write lock
        rd_time(t0);
        wr_lock_i = 1'b1;
        wr(3'd1, 16'hDEAD); wr(3'd2, 16'hBEEF);
        rd(3'd5, rv); chk("R6 locked ctrl", {16'h0, rv}, 32'h8000);
        rd_time(t); chk("R6 locked count", t, t0);
        rd(3'd0, rv); chk("R6 locked wcnt", {16'h0, rv}, {16'h0, wc_prev});
        pulse_pps; rd_time(t); chk("R6 old count advances", t, t0 + 32'd1);
        wr_lock_i = 1'b0;

        // R9: alarm
        wr(3'd3, 16'h0000); wr(3'd4, 16'h0100);
        wr(3'd5, 16'h0400);
        set_time(32'h000000FE);
        base = alm_pulses;
        pulse_pps; repeat (5) @(negedge clk);
        chk("R9 no pulse before match", 32'(alm_pulses - base), 32'd0);
        pulse_pps; repeat (5) @(negedge clk);
        chk("R9 single pulse on match", 32'(alm_pulses - base), 32'd1);
        repeat (20) @(negedge clk);
        chk("R9 no repeat while equal", 32'(alm_pulses - base), 32'd1);
        wr(3'd5, 16'h0000);
        set_time(32'h000000FF);
        base = alm_pulses;
        pulse_pps; repeat (5) @(negedge clk);
        rd_time(t); chk("R9 count at alarm", t, 32'h00000100);
        chk("R9 disabled no pulse", 32'(alm_pulses - base), 32'd0);
        wr(3'd5, 16'h0400); repeat (5) @(negedge clk);
        chk("R9 enable while equal", 32'(alm_pulses - base), 32'd1);
        wr(3'd5, 16'h0000);

        // R10: periodic sweep over every rate field value
        sub_tick_i = 1'b1;
        for (int n = 0; n < 8; n++) begin
            wr(3'd5, 16'(n << 4));
            repeat (4) @(negedge clk);
            if (n == 0) begin
                int seen = 0;
                for (int c = 0; c < 2000; c++) begin
                    @(negedge clk);
                    if (periodic_irq_o) seen++;
                end
                chk("R10 rate zero silent", 32'(seen), 32'd0);
            end else begin
                int gap = 0;
                int lim = 0;
                while (!periodic_irq_o && lim < 40000) begin @(negedge clk); lim++; end
                @(negedge clk); gap = 1;
                while (!periodic_irq_o && gap < 40000) begin @(negedge clk); gap++; end
                chk("R10 period", 32'(gap), 32'(1 << (15 - n)));
            end
        end
        sub_tick_i = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule